// File: doc/BRIEF.md
# Cascaded Cumulant Threshold Classifier

This block assigns a modulation class to a stream of higher-order-statistics feature vectors. Each vector holds three unsigned fixed-point magnitudes: the fourth-order cumulants |C40| and |C42|, and the sixth-order cumulant |C61|. A valid strobe marks each vector. The vectors pass through three threshold stages, ordered from coarse to fine.

The first stage tests for Gaussianity. A small |C42| marks the input as noise-like or multicarrier. The second stage compares the ratio |C40|/|C42| against two programmable ratio thresholds. It splits phase-shift keying from the amplitude-phase constellations, and it splits the two amplitude-phase orders. The third stage looks at |C61| to separate the phase-shift pair, which the fourth-order ratio cannot tell apart. A stage that settles the class does not activate the later stages for that vector. Its label is carried through them unchanged, so every result leaves after the same fixed delay.

The thresholds are static inputs that an outer configuration block drives. They must stay constant while vectors are in flight. A new vector may arrive on every clock cycle.

Top module: `cumulant_tree_classifier`

## Requirements
- R1: While reset is asserted and right after it is released, outValid is 0 and outLabel is 0.
- R2: outValid equals inValid delayed by exactly 3 clock cycles. A vector is accepted on every cycle that inValid is high, and back-to-back vectors are classified independently.
- R3: If c42Mag < gaussThr (strictly less), the label is 0 (Gaussian/multicarrier), whatever the other features are.
- R4: For a vector that is not Gaussian, if c40Mag·256 > pskRatio·c42Mag, the vector belongs to the phase-shift family and goes on to the third stage. The ratio thresholds have 8 fractional bits. Equality counts as not phase-shift.
- R5: A non-Gaussian vector that is not phase-shift gets label 3 (16-QAM) if c40Mag·256 > qamRatio·c42Mag, and label 4 (64-QAM) otherwise, including equality.
- R6: A phase-shift vector gets label 1 (BPSK) if c61Mag ≥ bpskThr. Otherwise it gets label 7 (unknown) if c61Mag < unkThr, and otherwise label 2 (QPSK/PSK). The test against bpskThr takes priority.
- R7: A vector decided at stage one does not activate stage two or stage three. A vector decided at stage two does not activate stage three. In both cases the decided label reaches outLabel unchanged, so a Gaussian vector with phase-shift-like c40Mag and c61Mag still gives label 0.
- R8: When outValid is high, outLabel is one of 0, 1, 2, 3, 4 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Feature vector valid strobe |
| c40Mag | input | FEAT_W | abs(C40) magnitude, unsigned fixed point |
| c42Mag | input | FEAT_W | abs(C42) magnitude, same scale as c40Mag |
| c61Mag | input | FEAT_W | abs(C61) magnitude, unsigned fixed point |
| gaussThr | input | FEAT_W | Gaussianity threshold on c42Mag |
| pskRatio | input | RAT_W | Phase-shift ratio threshold, 8 fractional bits |
| qamRatio | input | RAT_W | 16-QAM/64-QAM ratio threshold, 8 fractional bits |
| bpskThr | input | FEAT_W | c61Mag threshold for BPSK |
| unkThr | input | FEAT_W | c61Mag floor below which a phase-shift vector is unknown |
| outValid | output | 1 | Label valid, 3 cycles after inValid |
| outLabel | output | 3 | Class label |

## Verification
On every cycle, the assertions check these properties:
- the fixed three-cycle valid delay;
- that labels stay legal;
- that a Gaussian input always comes out as label 0;
- that a stage-one decision never activates the third stage and leaves its label untouched.

The actual class boundaries need the bench's scenarios, where exact-equality cases sit on each ratio and |C61| threshold:
- the ratio splits;
- the |C61| priority order;
- the strict versus inclusive comparisons.

The bench also covers a second threshold set and gapped or back-to-back streams of mixed classes.

// File: rtl/ccls_pkg.sv
package ccls_pkg;
  localparam int NUM_STAGES = 3;

  localparam logic [2:0] LBL_GAUSS = 3'd0;
  localparam logic [2:0] LBL_BPSK  = 3'd1;
  localparam logic [2:0] LBL_QPSK  = 3'd2;
  localparam logic [2:0] LBL_QAM16 = 3'd3;
  localparam logic [2:0] LBL_QAM64 = 3'd4;
  localparam logic [2:0] LBL_UNK   = 3'd7;

  // Strobes from control to datapath, one bit per stage.
  typedef struct packed {
    logic [NUM_STAGES-1:0] adv;   // a vector enters stage k this cycle
    logic [NUM_STAGES-1:0] eval;  // stage k must compute (vector still undecided)
  } stage_strobe_t;
endpackage

// File: rtl/ccls_control.sv
module ccls_control
  import ccls_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          done1,
  input  logic          done2,
  output stage_strobe_t stb,
  output logic          outValid
);
  logic [NUM_STAGES-1:0] vldPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldPipe <= '0;
    end else begin
      vldPipe <= {vldPipe[NUM_STAGES-2:0], inValid};
    end
  end

  always_comb begin
    stb.adv[0]  = inValid;
    stb.eval[0] = inValid;
    stb.adv[1]  = vldPipe[0];
    stb.eval[1] = vldPipe[0] & ~done1;
    stb.adv[2]  = vldPipe[1];
    stb.eval[2] = vldPipe[1] & ~done2;
  end

  assign outValid = vldPipe[NUM_STAGES-1];
endmodule

// File: rtl/ccls_datapath.sv
module ccls_datapath
  import ccls_pkg::*;
#(
  parameter int FEAT_W   = 18,
  parameter int RAT_W    = 10,
  parameter int RAT_FRAC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  stage_strobe_t     stb,
  input  logic [FEAT_W-1:0] c40In,
  input  logic [FEAT_W-1:0] c42In,
  input  logic [FEAT_W-1:0] c61In,
  input  logic [FEAT_W-1:0] gaussThr,
  input  logic [RAT_W-1:0]  pskRatio,
  input  logic [RAT_W-1:0]  qamRatio,
  input  logic [FEAT_W-1:0] bpskThr,
  input  logic [FEAT_W-1:0] unkThr,
  output logic              done1,
  output logic              done2,
  output logic [2:0]        outLabel
);
  localparam int SHIFT_W = FEAT_W + RAT_FRAC;
  localparam int MUL_W   = FEAT_W + RAT_W;
  localparam int PROD_W  = (SHIFT_W > MUL_W ? SHIFT_W : MUL_W) + 1;

  // Stage 1: Gaussianity test
  logic              isGauss;
  logic [2:0]        lbl1;
  logic [FEAT_W-1:0] c40S1, c42S1, c61S1;

  assign isGauss = c42In < gaussThr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done1 <= 1'b0;
      lbl1  <= LBL_GAUSS;
      c40S1 <= '0;
      c42S1 <= '0;
      c61S1 <= '0;
    end else if (stb.adv[0]) begin
      done1 <= isGauss;
      lbl1  <= isGauss ? LBL_GAUSS : LBL_UNK;
      if (stb.eval[0] && !isGauss) begin
        c40S1 <= c40In;
        c42S1 <= c42In;
        c61S1 <= c61In;
      end
    end
  end

  // Stage 2: cross-multiplied ratio tests
  logic [PROD_W-1:0] c40Scaled, pskRhs, qamRhs;
  logic              pskHit, qam16Hit;
  logic [2:0]        lbl2;
  logic [FEAT_W-1:0] c61S2;

  assign c40Scaled = PROD_W'(c40S1) << RAT_FRAC;
  assign pskRhs    = PROD_W'(pskRatio) * PROD_W'(c42S1);
  assign qamRhs    = PROD_W'(qamRatio) * PROD_W'(c42S1);
  assign pskHit    = c40Scaled > pskRhs;
  assign qam16Hit  = c40Scaled > qamRhs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done2 <= 1'b0;
      lbl2  <= LBL_GAUSS;
      c61S2 <= '0;
    end else if (stb.adv[1]) begin
      if (stb.eval[1]) begin
        done2 <= ~pskHit;
        if (pskHit) begin
          lbl2  <= LBL_UNK;
          c61S2 <= c61S1;
        end else begin
          lbl2 <= qam16Hit ? LBL_QAM16 : LBL_QAM64;
        end
      end else begin
        done2 <= 1'b1;
        lbl2  <= lbl1;
      end
    end
  end

  // Stage 3: sixth-order split of the phase-shift pair
  logic [2:0] pskLabel;

  always_comb begin
    if (c61S2 >= bpskThr)     pskLabel = LBL_BPSK;
    else if (c61S2 < unkThr)  pskLabel = LBL_UNK;
    else                      pskLabel = LBL_QPSK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLabel <= LBL_GAUSS;
    end else if (stb.adv[2]) begin
      outLabel <= stb.eval[2] ? pskLabel : lbl2;
    end
  end
endmodule

// File: rtl/cumulant_tree_classifier.sv
module cumulant_tree_classifier
  import ccls_pkg::*;
#(
  parameter int FEAT_W   = 18,
  parameter int RAT_W    = 10,
  parameter int RAT_FRAC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [FEAT_W-1:0] c40Mag,
  input  logic [FEAT_W-1:0] c42Mag,
  input  logic [FEAT_W-1:0] c61Mag,
  input  logic [FEAT_W-1:0] gaussThr,
  input  logic [RAT_W-1:0]  pskRatio,
  input  logic [RAT_W-1:0]  qamRatio,
  input  logic [FEAT_W-1:0] bpskThr,
  input  logic [FEAT_W-1:0] unkThr,
  output logic              outValid,
  output logic [2:0]        outLabel
);
  stage_strobe_t stb;
  logic          done1, done2;

  ccls_control uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .done1    (done1),
    .done2    (done2),
    .stb      (stb),
    .outValid (outValid)
  );

  ccls_datapath #(
    .FEAT_W   (FEAT_W),
    .RAT_W    (RAT_W),
    .RAT_FRAC (RAT_FRAC)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .c40In    (c40Mag),
    .c42In    (c42Mag),
    .c61In    (c61Mag),
    .gaussThr (gaussThr),
    .pskRatio (pskRatio),
    .qamRatio (qamRatio),
    .bpskThr  (bpskThr),
    .unkThr   (unkThr),
    .done1    (done1),
    .done2    (done2),
    .outLabel (outLabel)
  );
endmodule

// File: rtl/ccls_checker.sv
module ccls_checker
  import ccls_pkg::*;
#(
  parameter int FEAT_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [FEAT_W-1:0] c42Mag,
  input logic [FEAT_W-1:0] gaussThr,
  input logic              outValid,
  input logic [2:0]        outLabel,
  input stage_strobe_t     stb,
  input logic              done1,
  input logic              done2
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN)                 sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd0) |-> (!outValid && outLabel == LBL_GAUSS));

  a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));

  a_r3_gauss_label: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && $past(inValid && (c42Mag < gaussThr), 3))
      |-> (outValid && outLabel == LBL_GAUSS));

  a_r7_no_stage3_after_early: assert property (@(posedge clk) disable iff (!rstN)
    (stb.adv[1] && done1) |=> (done2 && !stb.eval[2]));

  a_r7_early_label_kept: assert property (@(posedge clk) disable iff (!rstN)
    (stb.adv[1] && done1) |=> ##1 (outLabel == LBL_GAUSS));

  a_r8_legal_label: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLabel <= LBL_QAM64 || outLabel == LBL_UNK));
endmodule

bind cumulant_tree_classifier ccls_checker #(.FEAT_W(FEAT_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .c42Mag   (c42Mag),
  .gaussThr (gaussThr),
  .outValid (outValid),
  .outLabel (outLabel),
  .stb      (stb),
  .done1    (done1),
  .done2    (done2)
);

// File: tb/cumulant_tree_classifier_test.sv
`timescale 1ns/1ps
module cumulant_tree_classifier_test;
  localparam int FEAT_W = 18;
  localparam int RAT_W  = 10;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic [FEAT_W-1:0] c40Mag = '0, c42Mag = '0, c61Mag = '0;
  logic [FEAT_W-1:0] gaussThr = 18'd1000, bpskThr = 18'd5000, unkThr = 18'd500;
  logic [RAT_W-1:0]  pskRatio = 10'd230, qamRatio = 10'd154;
  logic              outValid;
  logic [2:0]        outLabel;

  int nChecks = 0;
  int nFails  = 0;

  // expected pipeline: index 0 = newest
  logic       expV [3];
  logic [2:0] expL [3];
  string      expT [3];

  always #2.5 clk = ~clk;

  cumulant_tree_classifier #(.FEAT_W(FEAT_W), .RAT_W(RAT_W)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .c40Mag(c40Mag), .c42Mag(c42Mag), .c61Mag(c61Mag),
    .gaussThr(gaussThr), .pskRatio(pskRatio), .qamRatio(qamRatio),
    .bpskThr(bpskThr), .unkThr(unkThr),
    .outValid(outValid), .outLabel(outLabel)
  );

  function automatic logic [2:0] model(input longint a40, input longint a42, input longint a61);
    if (a42 < longint'(gaussThr)) return 3'd0;
    if (a40 * 256 > longint'(pskRatio) * a42) begin
      if (a61 >= longint'(bpskThr)) return 3'd1;
      if (a61 < longint'(unkThr))   return 3'd7;
      return 3'd2;
    end
    if (a40 * 256 > longint'(qamRatio) * a42) return 3'd3;
    return 3'd4;
  endfunction

  function automatic string tagOf(input logic [2:0] l);
    if (l == 3'd0) return "R3";
    if (l == 3'd3 || l == 3'd4) return "R5";
    return "R6";
  endfunction

  task automatic checkVal(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: check outputs due now, then drive the next input.
  task automatic step(input logic v, input int a40, input int a42, input int a61, input string tag);
    logic [2:0] l;
    @(negedge clk);
    checkVal("R2 outValid", int'(outValid), int'(expV[2]));
    if (expV[2]) begin
      checkVal({expT[2], " label"}, int'(outLabel), int'(expL[2]));
      checkVal("R8 legal", int'(outLabel <= 3'd4 || outLabel == 3'd7), 1);
    end
    expV[2] = expV[1]; expL[2] = expL[1]; expT[2] = expT[1];
    expV[1] = expV[0]; expL[1] = expL[0]; expT[1] = expT[0];
    inValid = v;
    c40Mag  = FEAT_W'(a40);
    c42Mag  = FEAT_W'(a42);
    c61Mag  = FEAT_W'(a61);
    l = model(a40, a42, a61);
    expV[0] = v;
    expL[0] = l;
    expT[0] = (tag == "") ? tagOf(l) : tag;
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) step(1'b0, 0, 0, 0, "R2");
  endtask

  task automatic randomRun(input int n);
    int a42, a40, a61;
    for (int i = 0; i < n; i++) begin
      a42 = int'($urandom_range(0, 60000));
      a40 = int'((longint'(a42) * $urandom_range(0, 1300)) / 1000);
      if (a40 > 262143) a40 = 262143;
      a61 = int'($urandom_range(0, 9000));
      step(($urandom_range(0, 3) != 0), a40, a42, a61, "");
    end
  endtask

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7458));
    for (int i = 0; i < 3; i++) begin expV[i] = 1'b0; expL[i] = 3'd0; expT[i] = "R2"; end

    repeat (3) @(negedge clk);
    checkVal("R1 outValid in reset", int'(outValid), 0);
    checkVal("R1 outLabel in reset", int'(outLabel), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 outValid after reset", int'(outValid), 0);
    checkVal("R1 outLabel after reset", int'(outLabel), 0);

    // Directed corner cases, back to back (R2)
    step(1, 5000, 999, 9000, "R7 gauss bypass");
    step(1, 920, 999, 9000, "R3 below gauss thr");
    step(1, 616, 1000, 0, "R3 equal gauss thr");
    step(1, 920, 1024, 9000, "R4 ratio equal not psk");
    step(1, 921, 1024, 5000, "R6 c61 equal bpsk thr");
    step(1, 921, 1024, 500, "R6 c61 equal unk thr");
    step(1, 921, 1024, 499, "R6 below unk thr");
    step(1, 616, 1024, 9000, "R5 qam equal 64");
    step(1, 617, 1024, 9000, "R5 qam above 16");
    step(1, 2000, 1024, 9000, "R4 psk bpsk");
    drain();

    randomRun(1500);
    drain();

    // Second threshold set: nothing Gaussian, bpsk threshold below unk floor
    gaussThr = 18'd0; pskRatio = 10'd512; qamRatio = 10'd300;
    bpskThr = 18'd200; unkThr = 18'd4000;
    step(1, 0, 0, 0, "R5 zero vector not gauss");
    step(1, 3000, 1000, 200, "R6 bpsk priority over unk");
    step(1, 3000, 1000, 199, "R6 unknown");
    step(1, 2000, 1000, 9000, "R4 ratio equal not psk");
    drain();
    randomRun(1500);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule